// File: doc/BRIEF.md
# Power-Down Freeze Wrapper

This block sits between a device's pins and its logic core and freezes the core while a power-down request is active. When the request starts, the wrapper presents the pin output values and output-enable states it last sampled on a clock edge. It blocks every core input, including the pin data and the clock enable, so that neither input changes nor clock edges reach the core. When the request ends, the freeze continues for a programmable number of clock cycles and then releases. While the freeze is active, a status output is high.

A configuration bit decides what the control pin does. When the bit is set, the pin is the power-down request and never reaches the core. When the bit is clear, no freeze can start and the pin is delivered to the core as one more ordinary data input. The core's clock is stopped through a clock-enable output, not through a gated clock net.

Top module: `pd_hold_wrap`

## Requirements
- R1: After synchronous reset, with the control pin low and power-down enabled, `hold_active` is 0 and `core_clk_en` is 1.
- R2: With `pd_opt` = 0, the control pin never starts a freeze, and its level appears on bit `N_IN` of `core_in` in the same cycle.
- R3: With `pd_opt` = 1, bit `N_IN` of `core_in` is 0 whatever the level of the control pin.
- R4: With `pd_opt` = 1, a high control pin raises `hold_active` and drops `core_clk_en` in the same cycle, before any clock edge.
- R5: During a freeze, `pin_out` holds the value `core_out` had at the last rising clock edge before the freeze began, and later changes of `core_out` have no effect.
- R6: During a freeze, `pin_oe` holds the enable pattern of that same edge, so a bit that was 0 (high impedance) stays 0 even if `core_oe` rises.
- R7: During a freeze, `core_in` holds the value sampled at that same edge, and changes on `pin_in` have no effect.
- R8: If the control pin is first seen low at clock edge e0, `hold_active` stays high through edges e0 to e(RESUME_CYCLES-1) and falls right after edge eRESUME_CYCLES. At that point the pins pass through again.
- R9: If the control pin rises again during the resume countdown, the freeze resumes at once, and a later release restarts the full countdown.
- R10: Outside a freeze, `pin_out`, `pin_oe` and `core_in` follow `core_out`, `core_oe` and the live pins combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_opt | input | 1 | 1: control pin requests power-down; 0: pin is a data input |
| pd_pin | input | 1 | Control pin |
| pin_in | input | N_IN | Raw input pins |
| core_out | input | N_OUT | Output data from the core |
| core_oe | input | N_OUT | Output enables from the core (1 = drive) |
| core_in | output | N_IN+1 | Inputs delivered to the core; top bit carries the control pin when pd_opt is 0 |
| core_clk_en | output | 1 | Clock enable for the core's registers |
| pin_out | output | N_OUT | Output data toward the pads |
| pin_oe | output | N_OUT | Output enables toward the pads |
| hold_active | output | 1 | High while the freeze is in force |

## Verification
A wrong freeze state has one of two effects at the ports. Either `pin_out`, `pin_oe` or `core_in` starts to follow its live source while `hold_active` is high, or the status and clock enable release at the wrong edge. A premature release shows up within a clock cycle as live data on the pins. A bad shadow capture shows up in the very first frozen cycle, as a value that differs from the one at the last edge before the freeze. A countdown off by one changes the edge at which `hold_active` falls, and the bench samples that edge exactly, both on a plain release and on a release that follows a re-entered freeze.

// File: rtl/pdh_pkg.sv
package pdh_pkg;

    // Freeze controller phases
    typedef enum logic [1:0] {
        PH_RUN  = 2'd0,
        PH_HOLD = 2'd1,
        PH_WAKE = 2'd2
    } ph_state_e;

    // Control pin counts as a power-down request only when the option is set
    function automatic logic pd_request(input logic opt, input logic pin);
        return opt & pin;
    endfunction

    // Level forwarded to the core from the control pin
    function automatic logic pd_as_data(input logic opt, input logic pin);
        return opt ? 1'b0 : pin;
    endfunction

endpackage

// File: rtl/pdh_ctrl.sv
module pdh_ctrl
    import pdh_pkg::*;
#(
    parameter int RESUME_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic pd_req,
    output logic hold_sel
);
    localparam int CW = (RESUME_CYCLES > 1) ? $clog2(RESUME_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(RESUME_CYCLES - 1);

    ph_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PH_RUN: begin
                if (pd_req) state_d = PH_HOLD;
            end
            PH_HOLD: begin
                if (!pd_req) begin
                    state_d = PH_WAKE;
                    cnt_d   = LOAD_VAL;
                end
            end
            PH_WAKE: begin
                if (pd_req) begin
                    state_d = PH_HOLD;
                end else if (cnt_q == '0) begin
                    state_d = PH_RUN;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = PH_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Freeze takes effect as soon as the request appears
    assign hold_sel = pd_req | (state_q != PH_RUN);

endmodule

// File: rtl/pdh_hold_reg.sv
module pdh_hold_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic [W-1:0] live,
    output logic [W-1:0] seen
);
    logic [W-1:0] shadow_q;

    // Shadow tracks the live value on every edge outside a freeze
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
        end else if (!hold) begin
            shadow_q <= live;
        end
    end

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign seen[b] = hold ? shadow_q[b] : live[b];
    end

endmodule

// File: rtl/pd_hold_wrap.sv
module pd_hold_wrap
    import pdh_pkg::*;
#(
    parameter int N_IN          = 8,
    parameter int N_OUT         = 8,
    parameter int RESUME_CYCLES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pd_opt,
    input  logic             pd_pin,
    input  logic [N_IN-1:0]  pin_in,
    input  logic [N_OUT-1:0] core_out,
    input  logic [N_OUT-1:0] core_oe,
    output logic [N_IN:0]    core_in,
    output logic             core_clk_en,
    output logic [N_OUT-1:0] pin_out,
    output logic [N_OUT-1:0] pin_oe,
    output logic             hold_active
);
    localparam int IW = N_IN + 1;

    logic          pd_req;
    logic          hold_sel;
    logic [IW-1:0] live_in;

    assign pd_req  = pd_request(pd_opt, pd_pin);
    assign live_in = {pd_as_data(pd_opt, pd_pin), pin_in};

    pdh_ctrl #(.RESUME_CYCLES(RESUME_CYCLES)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .pd_req   (pd_req),
        .hold_sel (hold_sel)
    );

    pdh_hold_reg #(.W(IW)) u_in_hold (
        .clk  (clk),
        .rst  (rst),
        .hold (hold_sel),
        .live (live_in),
        .seen (core_in)
    );

    pdh_hold_reg #(.W(N_OUT)) u_dat_hold (
        .clk  (clk),
        .rst  (rst),
        .hold (hold_sel),
        .live (core_out),
        .seen (pin_out)
    );

    pdh_hold_reg #(.W(N_OUT)) u_oe_hold (
        .clk  (clk),
        .rst  (rst),
        .hold (hold_sel),
        .live (core_oe),
        .seen (pin_oe)
    );

    assign core_clk_en = ~hold_sel;
    assign hold_active = hold_sel;

endmodule

// File: rtl/pd_hold_wrap_chk.sv
module pd_hold_wrap_chk #(
    parameter int N_IN  = 8,
    parameter int N_OUT = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             pd_opt,
    input logic             pd_pin,
    input logic [N_IN-1:0]  pin_in,
    input logic [N_OUT-1:0] core_out,
    input logic [N_OUT-1:0] core_oe,
    input logic [N_IN:0]    core_in,
    input logic             core_clk_en,
    input logic [N_OUT-1:0] pin_out,
    input logic [N_OUT-1:0] pin_oe,
    input logic             hold_active
);
    assert_no_start_when_off_R2: assert property (@(posedge clk) disable iff (rst)
        (!pd_opt && !$past(hold_active)) |-> !hold_active);

    assert_pin_hidden_R3: assert property (@(posedge clk) disable iff (rst)
        (pd_opt && !hold_active) |-> (core_in[N_IN] == 1'b0));

    assert_request_freezes_R4: assert property (@(posedge clk) disable iff (rst)
        (pd_opt && pd_pin) |-> (hold_active && !core_clk_en));

    assert_data_held_R5: assert property (@(posedge clk) disable iff (rst)
        (hold_active && $past(hold_active)) |-> $stable(pin_out));

    assert_enable_held_R6: assert property (@(posedge clk) disable iff (rst)
        (hold_active && $past(hold_active)) |-> $stable(pin_oe));

    assert_inputs_blocked_R7: assert property (@(posedge clk) disable iff (rst)
        (hold_active && $past(hold_active)) |-> $stable(core_in));

    assert_passthrough_R10: assert property (@(posedge clk) disable iff (rst)
        !hold_active |-> (pin_out == core_out && pin_oe == core_oe
                          && core_in[N_IN-1:0] == pin_in && core_clk_en));
endmodule

bind pd_hold_wrap pd_hold_wrap_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pd_opt      (pd_opt),
    .pd_pin      (pd_pin),
    .pin_in      (pin_in),
    .core_out    (core_out),
    .core_oe     (core_oe),
    .core_in     (core_in),
    .core_clk_en (core_clk_en),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .hold_active (hold_active)
);

// File: tb/test_pd_hold_wrap.sv
module test_pd_hold_wrap;
    localparam int N_IN  = 8;
    localparam int N_OUT = 8;
    localparam int RES   = 3;

    logic             clk = 1'b0;
    logic             rst;
    logic             pd_opt;
    logic             pd_pin;
    logic [N_IN-1:0]  pin_in;
    logic [N_OUT-1:0] core_out;
    logic [N_OUT-1:0] core_oe;
    logic [N_IN:0]    core_in;
    logic             core_clk_en;
    logic [N_OUT-1:0] pin_out;
    logic [N_OUT-1:0] pin_oe;
    logic             hold_active;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pd_hold_wrap #(.N_IN(N_IN), .N_OUT(N_OUT), .RESUME_CYCLES(RES)) i_pd_hold_wrap (
        .clk(clk), .rst(rst), .pd_opt(pd_opt), .pd_pin(pd_pin), .pin_in(pin_in),
        .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
        .core_clk_en(core_clk_en), .pin_out(pin_out), .pin_oe(pin_oe),
        .hold_active(hold_active)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock edge, then settle to mid-low phase
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1; pd_opt = 1; pd_pin = 0; pin_in = '0; core_out = '0; core_oe = '0;
        step(); step();
        rst = 0;
        step();
        check("R1 hold", 32'(hold_active), 0);
        check("R1 clk_en", 32'(core_clk_en), 1);
        core_out = 8'h5A; core_oe = 8'hF0; pin_in = 8'h3C;
        #1;
        check("R10 pin_out", 32'(pin_out), 32'h5A);
        check("R10 pin_oe", 32'(pin_oe), 32'hF0);
        check("R10/R3 core_in", 32'(core_in), 32'h03C);
    endtask

    task automatic t_option_off();
        pd_opt = 0; pd_pin = 1;
        #1;
        check("R2 no hold", 32'(hold_active), 0);
        check("R2 pin to core", 32'(core_in[N_IN]), 1);
        step();
        check("R2 no hold after edge", 32'(hold_active), 0);
        check("R2 clk_en", 32'(core_clk_en), 1);
        pd_pin = 0;
        #1;
        check("R2 pin low to core", 32'(core_in[N_IN]), 0);
        pd_opt = 1;
        step();
    endtask

    task automatic t_freeze();
        core_out = 8'hA5; core_oe = 8'h0F; pin_in = 8'h11;
        step();
        pd_pin = 1; core_out = 8'hFF; core_oe = 8'hFF; pin_in = 8'hEE;
        #1;
        check("R4 hold", 32'(hold_active), 1);
        check("R4 clk_en", 32'(core_clk_en), 0);
        check("R3 pin hidden", 32'(core_in[N_IN]), 0);
        check("R5 data", 32'(pin_out), 32'hA5);
        check("R6 enables", 32'(pin_oe), 32'h0F);
        check("R7 inputs", 32'(core_in), 32'h011);
        for (int i = 0; i < 3; i++) begin
            core_out = 8'(i * 7); core_oe = 8'hF0; pin_in = 8'(i + 3);
            step();
            check("R5 data frozen", 32'(pin_out), 32'hA5);
            check("R6 hi-z kept", 32'(pin_oe), 32'h0F);
            check("R7 inputs frozen", 32'(core_in), 32'h011);
            check("R4 clk_en low", 32'(core_clk_en), 0);
        end
    endtask

    task automatic t_wake();
        pd_pin = 0; core_out = 8'h3C; core_oe = 8'hC3; pin_in = 8'h77;
        #1;
        check("R8 still held", 32'(hold_active), 1);
        check("R8 data held", 32'(pin_out), 32'hA5);
        for (int i = 0; i < RES; i++) begin
            step();
            check("R8 countdown", 32'(hold_active), 1);
            check("R8 data held", 32'(pin_out), 32'hA5);
        end
        step();
        check("R8 released", 32'(hold_active), 0);
        check("R8 clk_en", 32'(core_clk_en), 1);
        check("R8 data live", 32'(pin_out), 32'h3C);
        check("R8 enables live", 32'(pin_oe), 32'hC3);
        check("R8 inputs live", 32'(core_in), 32'h077);
    endtask

    task automatic t_rewake();
        core_out = 8'h96; core_oe = 8'h55; pin_in = 8'h22;
        step();
        pd_pin = 1; core_out = 8'h00;
        step(); step();
        pd_pin = 0;
        step(); step();
        check("R9 in countdown", 32'(hold_active), 1);
        pd_pin = 1;
        #1;
        check("R9 re-entry", 32'(hold_active), 1);
        check("R9 clk_en", 32'(core_clk_en), 0);
        step();
        pd_pin = 0;
        for (int i = 0; i < RES; i++) begin
            step();
            check("R9 full countdown", 32'(hold_active), 1);
            check("R9 data held", 32'(pin_out), 32'h96);
            check("R9 enables held", 32'(pin_oe), 32'h55);
        end
        step();
        check("R9 released", 32'(hold_active), 0);
        check("R9 data live", 32'(pin_out), 32'h00);
    endtask

    initial begin
        t_reset();
        t_option_off();
        t_freeze();
        t_wake();
        t_rewake();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule